// File: doc/BRIEF.md
# Bidirectional GPIO Bank with Pin-Change Wake and Edge Interrupt

This block holds a bank of general-purpose port bits. Each has an output latch and a direction bit, and both are changed through a small command interface. Software can write a whole port's latch, write a whole port's direction, or set, clear or invert one bit. A single-bit command works as read-modify-write: the block takes the port's current readback value, changes the addressed bit and stores the whole result in the latch. Readback is a mix, per bit, of the synchronized pad level for input bits and the latch for driven bits.

Some bits are output-only and always drive their latch. One pin doubles as an external interrupt input. The edge it reacts to is chosen by the output latch of another port bit. A wake-up group, made of one full port and the low half of another, raises a one-cycle wake request whenever any of its synchronized levels changes. Pad inputs pass through a two-flop synchronizer, and edge and wake detection stay quiet until that pipeline has filled after reset.

Top module: `gpio_bank`

## Requirements
- R1: After reset every direction bit is 1 (input) and every latch bit is 1, so `pad_out` is all ones, `pad_oe` equals the output-only mask (port 1 bits 4..2), and `irq_flag` and `wake_req` are 0.
- R2: Command op 1 writes `cmd_wdata` to the direction bits of port `cmd_port` at the clock edge; from then on `pad_oe` for each bit is the inverse of its direction bit, ORed with the output-only mask.
- R3: Command op 0 writes `cmd_wdata` to the latch of port `cmd_port`. A latch keeps its value until a later command changes it. Commands for another port, commands for a port index at or above the port count, and op codes 5 to 7 leave it unchanged.
- R4: `rd_data` returns, for port `rd_port`, the latch for bits whose `pad_oe` is 1 and the synchronized pad level for the others. The pad level shows up two clock edges after a pad change. An out-of-range `rd_port` reads 0.
- R5: Ops 2 (set), 3 (clear) and 4 (invert) take the readback value of port `cmd_port` (R4), change bit `cmd_bit`, and write all of the port's bits into its latch at the clock edge.
- R6: Output-only bits drive their latch value (`pad_oe` 1) and read back the latch, whatever their direction bit holds.
- R7: The interrupt pin (port 2 bit 2) sets `irq_flag` on a rising synchronized edge when the latch of port 1 bit 0 is 1, and on a falling edge when that latch is 0. The flag rises at the third clock edge after the pad change.
- R8: `irq_flag` stays set until `irq_clr` is high at a clock edge. If a new edge event arrives at the same edge as the clear, the flag stays set.
- R9: `wake_req` pulses for exactly one cycle, at the third edge after a level change on any bit of port 0 or port 2 bits 3..0. Changes on other bits raise no request.
- R10: For the first three edges after reset, no edge or wake event is raised, even if the pads differ from their reset level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 3 | 0 write latch, 1 write direction, 2 set bit, 3 clear bit, 4 invert bit |
| cmd_port | input | PW | Port index of the command |
| cmd_bit | input | BW | Bit index for single-bit ops |
| cmd_wdata | input | PORT_W | Data for whole-port writes |
| rd_port | input | PW | Port index for readback |
| rd_data | output | PORT_W | Mixed readback of the selected port |
| pad_in | input | NUM_PORTS*PORT_W | Pad levels, asynchronous |
| pad_out | output | NUM_PORTS*PORT_W | Output latch values to the pads |
| pad_oe | output | NUM_PORTS*PORT_W | Pad drive enable, 1 = driven |
| irq_clr | input | 1 | Clears the interrupt flag |
| irq_flag | output | 1 | Sticky external interrupt flag |
| wake_req | output | 1 | One-cycle wake-up request |

## Verification
Commands take effect at the edge that samples them, so the bench checks `pad_out`, `pad_oe` and driven-bit readback one cycle after each command. A pad change reaches `rd_data` after two edges and reaches `irq_flag` or `wake_req` after three. The bench waits exactly that many edges, and for the interrupt and wake results it also checks the cycle before, to show the result is not early. For `wake_req` it also checks the cycle after, to show the pulse is one cycle long. All samples are taken one nanosecond after a rising edge, and inputs change at that same point.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [2:0] {
    OP_WR_DATA = 3'd0,
    OP_WR_DIR  = 3'd1,
    OP_BSET    = 3'd2,
    OP_BCLR    = 3'd3,
    OP_BINV    = 3'd4
  } gp_op_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int          WIDTH   = 8,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int PORT_W    = 8,
  parameter logic [NUM_PORTS*PORT_W-1:0] OUT_ONLY_MASK = '0,
  localparam int NW = NUM_PORTS * PORT_W,
  localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int BW = (PORT_W > 1) ? $clog2(PORT_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [PW-1:0]     cmd_port,
  input  logic [BW-1:0]     cmd_bit,
  input  logic [PORT_W-1:0] cmd_wdata,
  input  logic [NW-1:0]     pad_sync,
  output logic [NW-1:0]     latch_o,
  output logic [NW-1:0]     oe_o,
  output logic [NW-1:0]     rb_o
);

  // Per bit: driven bits show the latch, released bits show the pad.
  function automatic logic [PORT_W-1:0] f_mix(input logic [PORT_W-1:0] lat,
                                              input logic [PORT_W-1:0] pad,
                                              input logic [PORT_W-1:0] oe);
    return (lat & oe) | (pad & ~oe);
  endfunction

  // Single-bit change of a whole-port value.
  function automatic logic [PORT_W-1:0] f_bitop(input logic [PORT_W-1:0] base,
                                                input logic [2:0]        op,
                                                input logic [BW-1:0]     bidx);
    logic [PORT_W-1:0] m;
    m = PORT_W'(1) << bidx;
    case (op)
      OP_BSET: return base | m;
      OP_BCLR: return base & ~m;
      OP_BINV: return base ^ m;
      default: return base;
    endcase
  endfunction

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [PORT_W-1:0] lat_q, dir_q, lat_d, dir_d;
    logic [PORT_W-1:0] oe_p, rb_p;
    logic              hit;

    assign hit  = cmd_valid && (cmd_port == PW'(p));
    assign oe_p = ~dir_q | OUT_ONLY_MASK[p*PORT_W +: PORT_W];
    assign rb_p = f_mix(lat_q, pad_sync[p*PORT_W +: PORT_W], oe_p);

    always_comb begin
      lat_d = lat_q;
      dir_d = dir_q;
      if (hit) begin
        case (cmd_op)
          OP_WR_DATA: lat_d = cmd_wdata;
          OP_WR_DIR:  dir_d = cmd_wdata;
          OP_BSET, OP_BCLR, OP_BINV: lat_d = f_bitop(rb_p, cmd_op, cmd_bit);
          default: ;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lat_q <= '1;
        dir_q <= '1;
      end else begin
        lat_q <= lat_d;
        dir_q <= dir_d;
      end
    end

    assign latch_o[p*PORT_W +: PORT_W] = lat_q;
    assign oe_o[p*PORT_W +: PORT_W]    = oe_p;
    assign rb_o[p*PORT_W +: PORT_W]    = rb_p;
  end

  // Assertion-side view of the addressed bit.
  logic in_range;
  int   flat_idx;
  assign in_range = int'(cmd_port) < NUM_PORTS;
  assign flat_idx = int'(cmd_port) * PORT_W + int'(cmd_bit);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(latch_o));

  p_bset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && in_range && cmd_op == OP_BSET) |=> latch_o[$past(flat_idx)]);

  p_bclr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && in_range && cmd_op == OP_BCLR) |=> !latch_o[$past(flat_idx)]);

  p_bad_op_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op > 3'd4) |=> $stable(latch_o) && $stable(oe_o));

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int NW      = 24,
  parameter int INT_IDX = 0,
  parameter logic [NW-1:0] WAKE_MASK = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NW-1:0] sync_i,
  input  logic          rise_sel,
  input  logic          irq_clr,
  output logic          irq_flag,
  output logic          wake_req,
  output logic          edge_evt,
  output logic          wake_evt
);

  logic [NW-1:0] prev_q;
  logic [2:0]    fill_q;
  logic          ready;
  logic          int_now, int_was;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '1;
      fill_q <= '0;
    end else begin
      prev_q <= sync_i;
      fill_q <= {fill_q[1:0], 1'b1};
    end
  end

  assign ready   = fill_q[2];
  assign int_now = sync_i[INT_IDX];
  assign int_was = prev_q[INT_IDX];

  assign edge_evt = ready && (rise_sel ? (int_now && !int_was)
                                       : (!int_now && int_was));
  assign wake_evt = ready && (((sync_i ^ prev_q) & WAKE_MASK) != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_flag <= 1'b0;
      wake_req <= 1'b0;
    end else begin
      irq_flag <= edge_evt || (irq_flag && !irq_clr);
      wake_req <= wake_evt;
    end
  end

  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clr) |=> irq_flag);

  p_irq_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !edge_evt) |=> !irq_flag);

  p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> (prev_q[INT_IDX] != $past(prev_q[INT_IDX])));

  p_wake_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> ((prev_q & WAKE_MASK) != ($past(prev_q) & WAKE_MASK)));

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int PORT_W    = 8,
  parameter logic [NUM_PORTS*PORT_W-1:0] OUT_ONLY_MASK = 24'h001C00,
  parameter logic [NUM_PORTS*PORT_W-1:0] WAKE_MASK     = 24'h0F00FF,
  parameter int INT_IDX  = 18,
  parameter int EDGE_IDX = 8,
  localparam int NW = NUM_PORTS * PORT_W,
  localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int BW = (PORT_W > 1) ? $clog2(PORT_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [PW-1:0]     cmd_port,
  input  logic [BW-1:0]     cmd_bit,
  input  logic [PORT_W-1:0] cmd_wdata,
  input  logic [PW-1:0]     rd_port,
  output logic [PORT_W-1:0] rd_data,
  input  logic [NW-1:0]     pad_in,
  output logic [NW-1:0]     pad_out,
  output logic [NW-1:0]     pad_oe,
  input  logic              irq_clr,
  output logic              irq_flag,
  output logic              wake_req
);

  logic [NW-1:0] pad_sync;
  logic [NW-1:0] latch_w, oe_w, rb_w;
  logic          edge_evt, wake_evt;

  gpio_sync #(.WIDTH(NW), .RST_VAL('1)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(pad_in),
    .sync_o (pad_sync)
  );

  gpio_port_regs #(
    .NUM_PORTS    (NUM_PORTS),
    .PORT_W       (PORT_W),
    .OUT_ONLY_MASK(OUT_ONLY_MASK)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .cmd_port (cmd_port),
    .cmd_bit  (cmd_bit),
    .cmd_wdata(cmd_wdata),
    .pad_sync (pad_sync),
    .latch_o  (latch_w),
    .oe_o     (oe_w),
    .rb_o     (rb_w)
  );

  gpio_edge_irq #(
    .NW       (NW),
    .INT_IDX  (INT_IDX),
    .WAKE_MASK(WAKE_MASK)
  ) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_i  (pad_sync),
    .rise_sel(latch_w[EDGE_IDX]),
    .irq_clr (irq_clr),
    .irq_flag(irq_flag),
    .wake_req(wake_req),
    .edge_evt(edge_evt),
    .wake_evt(wake_evt)
  );

  always_comb begin
    rd_data = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (rd_port == PW'(p)) rd_data = rb_w[p*PORT_W +: PORT_W];
  end

  assign pad_out = latch_w;
  assign pad_oe  = oe_w;

  p_oo_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_port) < NUM_PORTS) |->
      ((rd_data ^ pad_out[int'(rd_port)*PORT_W +: PORT_W])
        & OUT_ONLY_MASK[int'(rd_port)*PORT_W +: PORT_W]) == '0);

  p_no_early_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !edge_evt && !wake_evt);

endmodule

// File: tb/gpio_bank_tb.sv
`timescale 1ns/1ps
module gpio_bank_tb;

  localparam int NP = 3;
  localparam int W  = 8;
  localparam int NW = NP * W;
  localparam logic [NW-1:0] OO   = 24'h001C00;
  localparam logic [NW-1:0] WAKE = 24'h0F00FF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = '0;
  logic [1:0]    cmd_port = '0;
  logic [2:0]    cmd_bit = '0;
  logic [W-1:0]  cmd_wdata = '0;
  logic [1:0]    rd_port = '0;
  logic [W-1:0]  rd_data;
  logic [NW-1:0] pad_v = 24'hA53C96;
  logic [NW-1:0] pad_out, pad_oe;
  logic          irq_clr = 1'b0;
  logic          irq_flag, wake_req;

  int nvec = 0;
  int nerr = 0;
  logic [NW-1:0] lat_m = '1;
  logic [NW-1:0] dir_m = '1;

  always #2.5 clk = ~clk;

  gpio_bank u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_port(cmd_port), .cmd_bit(cmd_bit), .cmd_wdata(cmd_wdata),
    .rd_port(rd_port), .rd_data(rd_data), .pad_in(pad_v), .pad_out(pad_out),
    .pad_oe(pad_oe), .irq_clr(irq_clr), .irq_flag(irq_flag), .wake_req(wake_req)
  );

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NW-1:0] oe_exp();
    return ~dir_m | OO;
  endfunction

  function automatic logic [W-1:0] rb_exp(input int p);
    logic [NW-1:0] mix;
    mix = (lat_m & oe_exp()) | (pad_v & ~oe_exp());
    return mix[p*W +: W];
  endfunction

  task automatic do_cmd(input int op, input int p, input int b, input logic [W-1:0] d);
    logic [W-1:0] v;
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_port = 2'(p); cmd_bit = 3'(b); cmd_wdata = d;
    if (p < NP) begin
      case (op)
        0: lat_m[p*W +: W] = d;
        1: dir_m[p*W +: W] = d;
        2, 3, 4: begin
          v = rb_exp(p);
          if (op == 2) v[b] = 1'b1;
          else if (op == 3) v[b] = 1'b0;
          else v[b] = ~v[b];
          lat_m[p*W +: W] = v;
        end
        default: ;
      endcase
    end
    step(1);
    cmd_valid = 1'b0;
  endtask

  task automatic chk_all_reads(input string req);
    for (int q = 0; q < NP; q++) begin
      rd_port = 2'(q);
      #0.1;
      chk(req, 32'(rd_data), 32'(rb_exp(q)));
    end
  endtask

  initial begin : watchdog
    #(200000 * 5);
    nerr++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin : main
    step(3);
    rst_n = 1'b1;
    // R10: pads differ from the reset level, yet no event while priming
    for (int i = 0; i < 5; i++) begin
      chk("R10 wake after reset", 32'(wake_req), 32'd0);
      step(1);
    end
    chk("R10 irq after reset", 32'(irq_flag), 32'd0);
    // R1 reset state
    chk("R1 pad_out", 32'(pad_out), 32'hFFFFFF);
    chk("R1 pad_oe", 32'(pad_oe), 32'(OO));
    chk_all_reads("R1/R4 reset readback");

    // R2 R3 R4 R6: whole-port sweeps
    for (int p = 0; p < NP; p++) begin
      for (int k = 0; k < 6; k++) begin
        pad_v = 24'(k * 12345 + p * 999 + 7);
        do_cmd(1, p, 0, 8'((k * 151 + p * 17) ^ 8'h3C));
        do_cmd(0, p, 0, 8'(k * 73 + p * 29 + 5));
        step(1);
        chk("R2 pad_oe", 32'(pad_oe), 32'(oe_exp()));
        chk("R3 pad_out", 32'(pad_out), 32'(lat_m));
        chk_all_reads("R4/R6 readback");
      end
    end

    // R3: out-of-range port and reserved op codes have no effect
    do_cmd(0, 3, 0, 8'h00);
    do_cmd(5, 0, 0, 8'h00);
    do_cmd(7, 1, 0, 8'h00);
    do_cmd(6, 2, 0, 8'h00);
    chk("R3 ignored cmds pad_out", 32'(pad_out), 32'(lat_m));
    chk("R3 ignored cmds pad_oe", 32'(pad_oe), 32'(oe_exp()));
    rd_port = 2'd3; #0.1;
    chk("R4 out-of-range read", 32'(rd_data), 32'd0);

    // R5: read-modify-write bit ops over every bit of every port
    for (int p = 0; p < NP; p++) begin
      pad_v = 24'(p * 40503 + 24'h5A3C1);
      do_cmd(1, p, 0, 8'h5A ^ 8'(p));
      step(2);
      for (int b = 0; b < W; b++) begin
        for (int o = 2; o <= 4; o++) begin
          do_cmd(o, p, b, 8'h00);
          chk("R5 bit op latch", 32'(pad_out), 32'(lat_m));
        end
      end
      chk_all_reads("R5/R4 readback after bit ops");
    end

    // R7 R8: interrupt edges
    for (int p = 0; p < NP; p++) do_cmd(1, p, 0, 8'hFF);
    do_cmd(0, 1, 0, 8'h01);            // edge select = rising
    pad_v = '0;
    step(4);
    irq_clr = 1'b1; step(1); irq_clr = 1'b0;
    chk("R8 clear", 32'(irq_flag), 32'd0);
    pad_v[18] = 1'b1;
    step(2); chk("R7 rise not early", 32'(irq_flag), 32'd0);
    step(1); chk("R7 rise sets flag", 32'(irq_flag), 32'd1);
    step(3); chk("R8 flag holds", 32'(irq_flag), 32'd1);
    irq_clr = 1'b1; step(1); irq_clr = 1'b0;
    chk("R8 clear after hold", 32'(irq_flag), 32'd0);
    pad_v[18] = 1'b0;
    step(4); chk("R7 fall ignored when rising selected", 32'(irq_flag), 32'd0);
    do_cmd(0, 1, 0, 8'h00);            // edge select = falling
    pad_v[18] = 1'b1;
    step(4); chk("R7 rise ignored when falling selected", 32'(irq_flag), 32'd0);
    pad_v[18] = 1'b0;
    step(2); chk("R7 fall not early", 32'(irq_flag), 32'd0);
    step(1); chk("R7 fall sets flag", 32'(irq_flag), 32'd1);
    irq_clr = 1'b1; step(1); irq_clr = 1'b0;
    pad_v[18] = 1'b1;
    step(4);
    irq_clr = 1'b1;
    pad_v[18] = 1'b0;
    step(2); chk("R8 clear held", 32'(irq_flag), 32'd0);
    step(1); chk("R8 set beats clear", 32'(irq_flag), 32'd1);
    step(1); chk("R8 clear after collision", 32'(irq_flag), 32'd0);
    irq_clr = 1'b0;

    // R9: wake group
    step(4);
    pad_v[5] = ~pad_v[5];
    step(2); chk("R9 port0 wake not early", 32'(wake_req), 32'd0);
    step(1); chk("R9 port0 wake pulse", 32'(wake_req), 32'd1);
    step(1); chk("R9 wake one cycle", 32'(wake_req), 32'd0);
    pad_v[19] = ~pad_v[19];
    step(3); chk("R9 port2 low-nibble wake", 32'(wake_req), 32'd1);
    step(1);
    pad_v[15] = ~pad_v[15];
    for (int i = 0; i < 5; i++) begin
      step(1); chk("R9 port1 no wake", 32'(wake_req), 32'd0);
    end
    pad_v[22] = ~pad_v[22];
    for (int i = 0; i < 5; i++) begin
      step(1); chk("R9 port2 high bit no wake", 32'(wake_req), 32'd0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule